// File: doc/BRIEF.md
# Dual Reload Down-Counter Timer with Watchdog

This block is a register-mapped timer peripheral. It holds two general-purpose 32-bit down-counters and a third counter of the same shape that serves as a watchdog. Each counter has a reload register and a live count register, and software can read or write both over a simple single-cycle 32-bit register bus. A control word holds an enable bit and an auto-reload bit for every counter, interleaved per counter.

An enabled counter steps down by one on each clock cycle in which the `cnt_tick` strobe is high. The strobe comes from an external prescaler. In auto-reload mode a counter that is at zero on a tick restarts from its reload value. In one-shot mode it stays at zero and its enable bit drops. Each general timer gives a one-cycle expiry pulse when this happens. The watchdog instead raises a sticky reset request, which software clears by writing the watchdog's count register.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads zero, `tmr_expire` and `wdog_rst_req` are low, and all counters are disabled, so ticks leave every count at zero.
- R2: Register byte offsets (word-aligned): control 0x00, timer n reload 0x10+8n, timer n count 0x14+8n, watchdog reload 0x20, watchdog count 0x24. A reload register reads back the full 32-bit value last written.
- R3: An enabled counter with a nonzero count decreases by exactly one on each clock edge where `cnt_tick` is high, and does not change on edges where `cnt_tick` is low.
- R4: A bus write to a count register sets the count to the written value at that edge. It wins over a decrement or a reload in the same cycle, and it raises no expiry in that cycle.
- R5: When a counter is enabled, its auto-reload bit is set, and its count is zero on a tick, the count becomes the reload value.
- R6: When a counter is enabled, its auto-reload bit is clear, and its count is zero on a tick, the count stays zero and its enable bit clears. A control write in that same cycle takes precedence.
- R7: `tmr_expire[n]` is high for exactly the one cycle after each clock edge at which timer n was enabled, ticked and at zero. In every other cycle it is low.
- R8: The watchdog uses control bit 4 as its enable and bit 5 as its auto-reload. Its expiry sets `wdog_rst_req`, which stays high until a write to the watchdog count register clears it.
- R9: Reserved words (0x04 to 0x0C), offsets above 0x24 and offsets that are not word-aligned read as zero. Writes to them change no register.
- R10: Control bit layout: enable of counter n at bit 2n, auto-reload of counter n at bit 2n+1. Bits 6 and up read zero.
- R11: Read data appears on `bus_rdata` after the clock edge that samples a read request. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count strobe from an external prescaler |
| bus_en | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_expire | output | 2 | One-cycle expiry pulse per general timer |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
A write and a tick both take effect at the edge where they are presented, so every count or control value is read back only after that edge. Read data is registered: it is due one edge after the request, and the bench samples it at the falling edge that follows. Both the expiry pulse and the watchdog request come from registers updated at the tick edge that found the count at zero. The bench samples them at the next falling edge, and samples again one cycle later to confirm that the pulse has ended and that the watchdog request is still held.

// File: rtl/drt_pkg.sv
package drt_pkg;
   timeunit 1ns; timeprecision 100ps;

   // word index (byte offset / 4) of the shared control word
   localparam int unsigned CTRL_WORD    = 0;
   // first channel register word; channels occupy two words each
   localparam int unsigned CH_BASE_WORD = 4;

   function automatic int unsigned reload_word(input int unsigned ch);
      return CH_BASE_WORD + 2 * ch;
   endfunction

   function automatic int unsigned value_word(input int unsigned ch);
      return CH_BASE_WORD + 2 * ch + 1;
   endfunction

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_RELOAD = 2'd2,
      SEL_VALUE  = 2'd3
   } sel_kind_e;
endpackage

// File: rtl/drt_addr_dec.sv
module drt_addr_dec #(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned CH_IDX_W = 2
) (
   input  logic                  bus_en,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   output logic                  ctrl_we,
   output logic [NUM_CH-1:0]     reload_we,
   output logic [NUM_CH-1:0]     value_we,
   output logic                  rd_req,
   output drt_pkg::sel_kind_e    rd_kind,
   output logic [CH_IDX_W-1:0]   rd_ch
);
   timeunit 1ns; timeprecision 100ps;

   localparam int unsigned WA_W = ADDR_W - 2;

   logic              aligned;
   logic [WA_W-1:0]   word;
   logic              is_ctrl;
   logic [NUM_CH-1:0] hit_rel;
   logic [NUM_CH-1:0] hit_val;

   assign aligned = (bus_addr[1:0] == 2'b00);
   assign word    = bus_addr[ADDR_W-1:2];
   assign is_ctrl = aligned && (word == WA_W'(drt_pkg::CTRL_WORD));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
      assign hit_rel[c]   = aligned && (word == WA_W'(drt_pkg::reload_word(c)));
      assign hit_val[c]   = aligned && (word == WA_W'(drt_pkg::value_word(c)));
      assign reload_we[c] = bus_en & bus_wr & hit_rel[c];
      assign value_we[c]  = bus_en & bus_wr & hit_val[c];
   end

   assign ctrl_we = bus_en & bus_wr & is_ctrl;
   assign rd_req  = bus_en & ~bus_wr;

   always_comb begin
      rd_kind = drt_pkg::SEL_NONE;
      rd_ch   = '0;
      if (is_ctrl) rd_kind = drt_pkg::SEL_CTRL;
      for (int c = 0; c < NUM_CH; c++) begin
         if (hit_rel[c]) begin
            rd_kind = drt_pkg::SEL_RELOAD;
            rd_ch   = CH_IDX_W'(c);
         end
         if (hit_val[c]) begin
            rd_kind = drt_pkg::SEL_VALUE;
            rd_ch   = CH_IDX_W'(c);
         end
      end
   end
endmodule

// File: rtl/drt_ctrl_reg.sv
module drt_ctrl_reg #(
   parameter int unsigned NUM_CH = 3,
   localparam int unsigned CTRL_W = 2 * NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   input  logic [NUM_CH-1:0] stop,
   output logic [NUM_CH-1:0] en_q,
   output logic [NUM_CH-1:0] auto_q,
   output logic [CTRL_W-1:0] ctrl_q
);
   timeunit 1ns; timeprecision 100ps;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)       en_q[c] <= 1'b0;
         else if (we)      en_q[c] <= wdata[2*c];
         else if (stop[c]) en_q[c] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)  auto_q[c] <= 1'b0;
         else if (we) auto_q[c] <= wdata[2*c+1];
      end

      assign ctrl_q[2*c]   = en_q[c];
      assign ctrl_q[2*c+1] = auto_q[c];

      // R6: a one-shot stop clears the enable unless software rewrites it
      p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (stop[c] && !we) |=> !en_q[c]);
   end
endmodule

// File: rtl/drt_channel.sv
module drt_channel #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          IS_WDOG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              auto_rl,
   input  logic              reload_we,
   input  logic              value_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] reload_q,
   output logic [DATA_W-1:0] count_q,
   output logic              stop_req,
   output logic              flag_q
);
   timeunit 1ns; timeprecision 100ps;

   logic at_zero;
   logic expire_evt;

   assign at_zero    = (count_q == '0);
   assign expire_evt = en & tick & ~value_we & at_zero;
   assign stop_req   = expire_evt & ~auto_rl;

   always_ff @(posedge clk) begin
      if (!rst_n)         reload_q <= '0;
      else if (reload_we) reload_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          count_q <= '0;
      else if (value_we)   count_q <= wdata;
      else if (en && tick) begin
         if (!at_zero)     count_q <= count_q - DATA_W'(1);
         else if (auto_rl) count_q <= reload_q;
      end
   end

   if (IS_WDOG) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n)          flag_q <= 1'b0;
         else if (value_we)   flag_q <= 1'b0;
         else if (expire_evt) flag_q <= 1'b1;
      end

      // R8: the reset request is held until the count register is written
      p_wdog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q && !value_we) |=> flag_q);
   end else begin : g_pulse
      always_ff @(posedge clk) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= expire_evt;
      end

      // R7: each expiry pulse follows an enabled tick at zero
      p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (en && tick && at_zero && !value_we) |=> flag_q);
   end

   // R3: one step down per enabled tick
   p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !value_we && !at_zero) |=> (count_q == $past(count_q) - DATA_W'(1)));

   // R4: a count write wins over counting
   p_wr_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      value_we |=> (count_q == $past(wdata)));

   // R5: auto-reload restarts from the reload register
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && auto_rl && at_zero && !value_we) |=> (count_q == $past(reload_q)));

   // R3: no tick, no write, no change
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !value_we) |=> $stable(count_q));
endmodule

// File: rtl/drt_rd_mux.sv
module drt_rd_mux #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned CH_IDX_W = 2,
   localparam int unsigned CTRL_W  = 2 * NUM_CH
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rd_req,
   input  drt_pkg::sel_kind_e             rd_kind,
   input  logic [CH_IDX_W-1:0]            rd_ch,
   input  logic [CTRL_W-1:0]              ctrl_q,
   input  logic [NUM_CH-1:0][DATA_W-1:0]  reload_arr,
   input  logic [NUM_CH-1:0][DATA_W-1:0]  count_arr,
   output logic [DATA_W-1:0]              rdata
);
   timeunit 1ns; timeprecision 100ps;

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      unique case (rd_kind)
         drt_pkg::SEL_CTRL:   rd_val = DATA_W'(ctrl_q);
         drt_pkg::SEL_RELOAD: rd_val = reload_arr[rd_ch];
         drt_pkg::SEL_VALUE:  rd_val = count_arr[rd_ch];
         default:             rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_req) rdata <= rd_val;
   end

   // R9: unmapped reads return zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_kind == drt_pkg::SEL_NONE) |=> (rdata == '0));

   // R11: read data holds between reads
   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rdata));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned NUM_TMR = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cnt_tick,
   input  logic               bus_en,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_TMR-1:0] tmr_expire,
   output logic               wdog_rst_req
);
   timeunit 1ns; timeprecision 100ps;

   localparam int unsigned NUM_CH   = NUM_TMR + 1;
   localparam int unsigned CTRL_W   = 2 * NUM_CH;
   localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int unsigned TOP_WORD = drt_pkg::value_word(NUM_CH - 1);

   initial begin : g_param_chk
      assert (NUM_TMR >= 1) else $error("NUM_TMR must be at least 1");
      assert (CTRL_W <= DATA_W) else $error("control bits exceed DATA_W");
      assert (ADDR_W >= 3) else $error("ADDR_W too small");
      assert (TOP_WORD < (1 << (ADDR_W - 2))) else $error("map exceeds ADDR_W");
   end

   logic                          ctrl_we;
   logic [NUM_CH-1:0]             reload_we;
   logic [NUM_CH-1:0]             value_we;
   logic                          rd_req;
   drt_pkg::sel_kind_e            rd_kind;
   logic [CH_IDX_W-1:0]           rd_ch;
   logic [NUM_CH-1:0]             en_q;
   logic [NUM_CH-1:0]             auto_q;
   logic [CTRL_W-1:0]             ctrl_q;
   logic [NUM_CH-1:0]             stop_req;
   logic [NUM_CH-1:0]             flag_q;
   logic [NUM_CH-1:0][DATA_W-1:0] reload_arr;
   logic [NUM_CH-1:0][DATA_W-1:0] count_arr;

   drt_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_dec (
      .bus_en    (bus_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .ctrl_we   (ctrl_we),
      .reload_we (reload_we),
      .value_we  (value_we),
      .rd_req    (rd_req),
      .rd_kind   (rd_kind),
      .rd_ch     (rd_ch)
   );

   drt_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctrl_we),
      .wdata  (bus_wdata[CTRL_W-1:0]),
      .stop   (stop_req),
      .en_q   (en_q),
      .auto_q (auto_q),
      .ctrl_q (ctrl_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      drt_channel #(.DATA_W(DATA_W), .IS_WDOG(c == NUM_TMR)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (cnt_tick),
         .en        (en_q[c]),
         .auto_rl   (auto_q[c]),
         .reload_we (reload_we[c]),
         .value_we  (value_we[c]),
         .wdata     (bus_wdata),
         .reload_q  (reload_arr[c]),
         .count_q   (count_arr[c]),
         .stop_req  (stop_req[c]),
         .flag_q    (flag_q[c])
      );
   end

   drt_rd_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .rd_kind    (rd_kind),
      .rd_ch      (rd_ch),
      .ctrl_q     (ctrl_q),
      .reload_arr (reload_arr),
      .count_arr  (count_arr),
      .rdata      (bus_rdata)
   );

   assign tmr_expire   = flag_q[NUM_TMR-1:0];
   assign wdog_rst_req = flag_q[NUM_TMR];

   // R1: outputs are quiet in the cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (tmr_expire == '0 && !wdog_rst_req && bus_rdata == '0));
endmodule

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;
   timeunit 1ns; timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  tmr_expire;
   logic        wdog_rst_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dual_reload_timer uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cnt_tick     (cnt_tick),
      .bus_en       (bus_en),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .tmr_expire   (tmr_expire),
      .wdog_rst_req (wdog_rst_req)
   );

   // op: 0 write, 1 read (compare), 2 tick (data = count of ticks)
   localparam int NV = 26;
   localparam logic [71:0] VECS [NV] = '{
      {2'd0, 6'h10, 32'd5,          32'd0},  // t0 reload = 5
      {2'd0, 6'h14, 32'd3,          32'd0},  // t0 count = 3
      {2'd1, 6'h10, 32'd0,          32'd5},  // R2
      {2'd1, 6'h14, 32'd0,          32'd3},  // R4
      {2'd0, 6'h00, 32'h3,          32'd0},  // t0 enable + auto
      {2'd2, 6'h00, 32'd2,          32'd0},
      {2'd1, 6'h14, 32'd0,          32'd1},  // R3
      {2'd2, 6'h00, 32'd1,          32'd0},
      {2'd1, 6'h14, 32'd0,          32'd0},  // R3
      {2'd2, 6'h00, 32'd1,          32'd0},
      {2'd1, 6'h14, 32'd0,          32'd5},  // R5
      {2'd1, 6'h00, 32'd0,          32'h3},  // R10
      {2'd0, 6'h18, 32'd9,          32'd0},  // t1 reload
      {2'd0, 6'h1C, 32'd1,          32'd0},  // t1 count
      {2'd0, 6'h00, 32'h7,          32'd0},  // t1 enable, one-shot
      {2'd2, 6'h00, 32'd1,          32'd0},
      {2'd2, 6'h00, 32'd1,          32'd0},
      {2'd1, 6'h00, 32'd0,          32'h3},  // R6 enable dropped
      {2'd1, 6'h1C, 32'd0,          32'd0},  // R6 held at zero
      {2'd1, 6'h14, 32'd0,          32'd3},  // R3 t0 kept running
      {2'd0, 6'h08, 32'hFFFF_FFFF,  32'd0},  // reserved write
      {2'd1, 6'h08, 32'd0,          32'd0},  // R9
      {2'd0, 6'h15, 32'h77,         32'd0},  // misaligned write
      {2'd1, 6'h14, 32'd0,          32'd3},  // R9 count untouched
      {2'd1, 6'h28, 32'd0,          32'd0},  // R9 unmapped
      {2'd1, 6'h18, 32'd0,          32'd9}   // R2 t1 reload
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [5:0] a, input logic [31:0] d, input logic tk);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cnt_tick = tk;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0; cnt_tick = 1'b0;
   endtask

   task automatic do_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cnt_tick = 1'b1;
      end
      @(negedge clk);
      cnt_tick = 1'b0;
   endtask

   initial begin : wdog
      #100000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check("R1 expire", {30'd0, tmr_expire}, 32'd0);
      check("R1 wdog", {31'd0, wdog_rst_req}, 32'd0);
      for (int a = 0; a <= 'h24; a += 4) begin
         do_read(6'(a), rd);
         check($sformatf("R1 reg %02h", a), rd, 32'd0);
      end
      do_ticks(3);
      do_read(6'h14, rd);
      check("R1 disabled count", rd, 32'd0);
      check("R1 no pulse", {30'd0, tmr_expire}, 32'd0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         logic [1:0]  op;
         logic [5:0]  a;
         logic [31:0] d, e;
         {op, a, d, e} = VECS[v];
         case (op)
            2'd0: do_write(a, d, 1'b0);
            2'd1: begin
               do_read(a, rd);
               check($sformatf("vec %0d R2/R3/R5/R6/R9 addr %02h", v, a), rd, e);
            end
            default: do_ticks(int'(d));
         endcase
      end

      // R7: expiry pulse timing on timer 0 (enabled, auto)
      do_write(6'h10, 32'd2, 1'b0);
      do_write(6'h14, 32'd0, 1'b0);
      @(negedge clk); cnt_tick = 1'b1;
      @(negedge clk); cnt_tick = 1'b0;
      check("R7 pulse high", {30'd0, tmr_expire}, 32'd1);
      @(negedge clk);
      check("R7 pulse one cycle", {30'd0, tmr_expire}, 32'd0);
      do_read(6'h14, rd);
      check("R5 reload after pulse", rd, 32'd2);

      // R4: write with a tick in the same cycle
      do_write(6'h14, 32'd100, 1'b1);
      do_read(6'h14, rd);
      check("R4 write over decrement", rd, 32'd100);
      check("R4 no pulse on write", {30'd0, tmr_expire}, 32'd0);
      do_ticks(1);
      do_read(6'h14, rd);
      check("R3 after write", rd, 32'd99);

      // R8: watchdog one-shot
      do_write(6'h20, 32'd7, 1'b0);
      do_write(6'h24, 32'd1, 1'b0);
      do_write(6'h00, 32'h13, 1'b0);
      do_ticks(1);
      check("R8 not yet", {31'd0, wdog_rst_req}, 32'd0);
      @(negedge clk); cnt_tick = 1'b1;
      @(negedge clk); cnt_tick = 1'b0;
      check("R8 request set", {31'd0, wdog_rst_req}, 32'd1);
      repeat (3) @(negedge clk);
      check("R8 request sticky", {31'd0, wdog_rst_req}, 32'd1);
      do_read(6'h00, rd);
      check("R6 wdog enable cleared", rd, 32'h3);
      do_read(6'h24, rd);
      check("R8 wdog count zero", rd, 32'd0);
      do_write(6'h24, 32'd5, 1'b0);
      check("R8 cleared by write", {31'd0, wdog_rst_req}, 32'd0);

      // R11: read data holds with no new read
      do_read(6'h20, rd);
      repeat (2) @(negedge clk);
      check("R11 hold", bus_rdata, 32'd7);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule